// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block records when a precision-time-protocol packet passes the port. On the start-of-frame strobe of each packet it decides, from sideband fields that an upstream parser supplies (EtherType, UDP flag, UDP destination port, protocol version and message identifier), whether the packet belongs to the configured timestamp class. If it does, and the latch is empty, the 64-bit system time of that strobe cycle is stored and a valid flag is raised.

The stored value stays frozen until software reads the upper word. Until then, every further matching packet goes through unstamped. A per-packet status pair reports, one cycle after each start-of-frame, whether that packet received the stamp. As a result, at most one packet in flight carries the stamped flag, and software can pair the stored time with it without doubt. The same block serves either the transmit or the receive path.

Top module: `ptp_ts_capture`

## Requirements
- R1: After reset, `ts_valid`, `stat_vld` and `stat_ts` are 0, and `ts_lo` and `ts_hi` are 0.
- R2: In mode 2'b10 (version-2 event), a packet with EtherType 0x88F7, `pkt_ver` = 2 and a message type (low nibble of `pkt_msg_id`) below 4 is stamped. The cycle after its strobe, `ts_valid` is 1 and the stored time equals `sys_time` of the strobe cycle.
- R3: In mode 2'b10, a UDP packet with destination port 319, version 2 and message type 0 to 3 (this includes the path-delay types 2 and 3) is stamped. Message types 4 and above, and any other UDP port, are not stamped.
- R4: In mode 2'b01 (version-1 over UDP), a packet is stamped only when it is UDP to port 319, has `pkt_ver` = 1 and has `pkt_msg_id` equal to `cfg_v1_msg`. A different control byte is not stamped, and neither is an EtherType-0x88F7 frame without UDP.
- R5: While `ts_valid` is 1, a matching packet leaves `ts_lo` and `ts_hi` unchanged, and its `stat_ts` is 0.
- R6: A cycle with `rd_hi` = 1 clears `ts_valid` on the next edge. A matching strobe in that same cycle is still locked out. The first matching strobe after the clear is stamped.
- R7: `stat_vld` is 1 exactly in the cycle after each `sof`. `stat_ts` is 1 only in that cycle, and only when that packet was stamped.
- R8: With `cfg_enable` = 0, or with `cfg_mode` 2'b00 or 2'b11, no packet is stamped.
- R9: `ts_lo` holds bits 31:0 and `ts_hi` holds bits 63:32 of the stored time.
- R10: In mode 2'b10, a packet whose `pkt_ver` is not 2 is not stamped, even when its EtherType and message type would match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Capture enable |
| cfg_mode | input | 2 | Class select: 01 version-1 UDP, 10 version-2 event, others off |
| cfg_v1_msg | input | 8 | Control byte value to stamp in version-1 mode |
| sys_time | input | 64 | Free-running raw system time |
| sof | input | 1 | Start-of-frame strobe, one cycle per packet |
| pkt_etype | input | 16 | Packet EtherType |
| pkt_is_udp | input | 1 | Packet carries UDP |
| pkt_dport | input | 16 | UDP destination port |
| pkt_ver | input | 4 | Protocol version field |
| pkt_msg_id | input | 8 | Version-1 control byte, or version-2 type in low nibble |
| rd_hi | input | 1 | Software read of the upper timestamp word |
| ts_valid | output | 1 | Latch holds an unread timestamp |
| ts_lo | output | 32 | Stored time, lower word |
| ts_hi | output | 32 | Stored time, upper word |
| stat_vld | output | 1 | Per-packet status is valid this cycle |
| stat_ts | output | 1 | The packet reported this cycle was stamped |

## Verification
On every cycle, the assertions check four things: the stored time freezes while the latch is full; a rise of the valid flag carries the strobe-cycle time and a stamped status; an upper-word read empties the latch; and status pulses follow the strobes one for one. Only the directed scenarios can show which packets fall into which class in each mode: EtherType versus port, version mismatches, event versus general message types, and a non-matching control byte. The same is true of the off and reserved mode codes and of a read colliding with a strobe.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;
   typedef enum logic [1:0] {
      MODE_OFF    = 2'b00,
      MODE_V1_L4  = 2'b01,
      MODE_V2_EVT = 2'b10,
      MODE_RSVD   = 2'b11
   } ts_mode_e;

   localparam int PTP_ETYPE_DEF  = 16'h88F7;
   localparam int EVENT_PORT_DEF = 319;
   localparam int V2_EVT_TYPES   = 4;
endpackage

// File: rtl/ptp_ts_classifier.sv
module ptp_ts_classifier
   import ptp_ts_pkg::*;
#(
   parameter int ETYPE_W    = 16,
   parameter int PORT_W     = 16,
   parameter int VER_W      = 4,
   parameter int MSG_W      = 8,
   parameter int PTP_ETYPE  = PTP_ETYPE_DEF,
   parameter int EVENT_PORT = EVENT_PORT_DEF,
   parameter bit V1_EN      = 1'b1
) (
   input  logic [1:0]         cfg_mode,
   input  logic [MSG_W-1:0]   cfg_v1_msg,
   input  logic [ETYPE_W-1:0] pkt_etype,
   input  logic               pkt_is_udp,
   input  logic [PORT_W-1:0]  pkt_dport,
   input  logic [VER_W-1:0]   pkt_ver,
   input  logic [MSG_W-1:0]   pkt_msg_id,
   output logic               match
);
   localparam int TYPE_W = 4;

   logic on_l2, on_l4, v2_event, v2_hit, v1_hit;

   assign on_l2    = (pkt_etype == ETYPE_W'(PTP_ETYPE));
   assign on_l4    = pkt_is_udp && (pkt_dport == PORT_W'(EVENT_PORT));
   assign v2_event = (pkt_msg_id[TYPE_W-1:0] < TYPE_W'(V2_EVT_TYPES));
   assign v2_hit   = (cfg_mode == MODE_V2_EVT) && (pkt_ver == VER_W'(2))
                     && v2_event && (on_l2 || on_l4);

   generate
      if (V1_EN) begin : g_v1
         assign v1_hit = (cfg_mode == MODE_V1_L4) && (pkt_ver == VER_W'(1))
                         && on_l4 && (pkt_msg_id == cfg_v1_msg);
      end else begin : g_no_v1
         assign v1_hit = 1'b0;
      end
   endgenerate

   assign match = v1_hit || v2_hit;
endmodule

// File: rtl/ptp_ts_latch.sv
module ptp_ts_latch #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic              rd_hi,
   input  logic [TIME_W-1:0] now,
   output logic              full,
   output logic              took,
   output logic [TIME_W-1:0] stamp
);
   assign took = hit && !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full  <= 1'b0;
         stamp <= '0;
      end else begin
         if (took) begin
            full  <= 1'b1;
            stamp <= now;
         end else if (rd_hi) begin
            full <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ptp_ts_capture.sv
module ptp_ts_capture
   import ptp_ts_pkg::*;
#(
   parameter int TIME_W     = 64,
   parameter int WORD_W     = 32,
   parameter int ETYPE_W    = 16,
   parameter int PORT_W     = 16,
   parameter int VER_W      = 4,
   parameter int MSG_W      = 8,
   parameter int PTP_ETYPE  = PTP_ETYPE_DEF,
   parameter int EVENT_PORT = EVENT_PORT_DEF,
   parameter bit V1_EN      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_enable,
   input  logic [1:0]         cfg_mode,
   input  logic [MSG_W-1:0]   cfg_v1_msg,
   input  logic [TIME_W-1:0]  sys_time,
   input  logic               sof,
   input  logic [ETYPE_W-1:0] pkt_etype,
   input  logic               pkt_is_udp,
   input  logic [PORT_W-1:0]  pkt_dport,
   input  logic [VER_W-1:0]   pkt_ver,
   input  logic [MSG_W-1:0]   pkt_msg_id,
   input  logic               rd_hi,
   output logic               ts_valid,
   output logic [WORD_W-1:0]  ts_lo,
   output logic [WORD_W-1:0]  ts_hi,
   output logic               stat_vld,
   output logic               stat_ts
);
   generate
      if (TIME_W != 2 * WORD_W) begin : g_bad_split
         $error("TIME_W must be twice WORD_W");
      end
      if (MSG_W < 4 || VER_W < 2) begin : g_bad_fields
         $error("message field needs 4 bits, version field 2 bits");
      end
   endgenerate

   logic              cls_match, hit, took;
   logic [TIME_W-1:0] stamp;
   logic              stat_vld_q, stat_ts_q;

   ptp_ts_classifier #(
      .ETYPE_W(ETYPE_W), .PORT_W(PORT_W), .VER_W(VER_W), .MSG_W(MSG_W),
      .PTP_ETYPE(PTP_ETYPE), .EVENT_PORT(EVENT_PORT), .V1_EN(V1_EN)
   ) u_cls (
      .cfg_mode  (cfg_mode),
      .cfg_v1_msg(cfg_v1_msg),
      .pkt_etype (pkt_etype),
      .pkt_is_udp(pkt_is_udp),
      .pkt_dport (pkt_dport),
      .pkt_ver   (pkt_ver),
      .pkt_msg_id(pkt_msg_id),
      .match     (cls_match)
   );

   assign hit = sof && cfg_enable && cls_match;

   ptp_ts_latch #(.TIME_W(TIME_W)) u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .hit  (hit),
      .rd_hi(rd_hi),
      .now  (sys_time),
      .full (ts_valid),
      .took (took),
      .stamp(stamp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_vld_q <= 1'b0;
         stat_ts_q  <= 1'b0;
      end else begin
         stat_vld_q <= sof;
         stat_ts_q  <= took;
      end
   end

   assign stat_vld = stat_vld_q;
   assign stat_ts  = stat_ts_q;
   assign ts_lo    = stamp[WORD_W-1:0];
   assign ts_hi    = stamp[TIME_W-1:WORD_W];
endmodule

// File: rtl/ptp_ts_capture_chk.sv
module ptp_ts_capture_chk #(
   parameter int TIME_W = 64,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_enable,
   input logic [TIME_W-1:0] sys_time,
   input logic              sof,
   input logic              rd_hi,
   input logic              ts_valid,
   input logic [WORD_W-1:0] ts_lo,
   input logic [WORD_W-1:0] ts_hi,
   input logic              stat_vld,
   input logic              stat_ts
);
   p_hold_while_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ts_valid) |-> $stable({ts_hi, ts_lo}));

   p_capture_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ts_valid) |-> ({ts_hi, ts_lo} == $past(sys_time)));

   p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ts_valid && rd_hi) |=> !ts_valid);

   p_status_follows_sof_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> stat_vld);

   p_no_status_without_sof_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sof |=> !stat_vld);

   p_stamp_implies_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_ts |-> (ts_valid && stat_vld));

   p_rise_has_stamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ts_valid) |-> stat_ts);

   p_stamp_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_ts |-> $past(cfg_enable));
endmodule

bind ptp_ts_capture ptp_ts_capture_chk #(.TIME_W(TIME_W), .WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_enable(cfg_enable),
   .sys_time  (sys_time),
   .sof       (sof),
   .rd_hi     (rd_hi),
   .ts_valid  (ts_valid),
   .ts_lo     (ts_lo),
   .ts_hi     (ts_hi),
   .stat_vld  (stat_vld),
   .stat_ts   (stat_ts)
);

// File: tb/ptp_ts_capture_tb_top.sv
module ptp_ts_capture_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b0;
   logic [1:0]  cfg_mode = 2'b00;
   logic [7:0]  cfg_v1_msg = 8'h00;
   logic [63:0] sys_time = '0;
   logic        sof = 1'b0;
   logic [15:0] pkt_etype = '0;
   logic        pkt_is_udp = 1'b0;
   logic [15:0] pkt_dport = '0;
   logic [3:0]  pkt_ver = '0;
   logic [7:0]  pkt_msg_id = '0;
   logic        rd_hi = 1'b0;
   logic        ts_valid, stat_vld, stat_ts;
   logic [31:0] ts_lo, ts_hi;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   ptp_ts_capture dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
      .cfg_v1_msg(cfg_v1_msg), .sys_time(sys_time), .sof(sof),
      .pkt_etype(pkt_etype), .pkt_is_udp(pkt_is_udp), .pkt_dport(pkt_dport),
      .pkt_ver(pkt_ver), .pkt_msg_id(pkt_msg_id), .rd_hi(rd_hi),
      .ts_valid(ts_valid), .ts_lo(ts_lo), .ts_hi(ts_hi),
      .stat_vld(stat_vld), .stat_ts(stat_ts)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] et, input logic udp, input logic [15:0] dp,
                       input logic [3:0] ver, input logic [7:0] msg,
                       input logic [63:0] t, input logic hi);
      @(negedge clk);
      pkt_etype = et; pkt_is_udp = udp; pkt_dport = dp; pkt_ver = ver;
      pkt_msg_id = msg; sys_time = t; sof = 1'b1; rd_hi = hi;
      @(negedge clk);
      sof = 1'b0; rd_hi = 1'b0; sys_time = ~t;
   endtask

   task automatic read_hi();
      @(negedge clk);
      rd_hi = 1'b1;
      @(negedge clk);
      rd_hi = 1'b0;
      chk("R6 cleared by read", ts_valid, 0);
   endtask

   task automatic expect_stamp(input string req, input logic [63:0] t);
      chk({req, " stat_vld"}, stat_vld, 1);
      chk({req, " stat_ts"}, stat_ts, 1);
      chk({req, " ts_valid"}, ts_valid, 1);
      chk("R9 low word", ts_lo, t[31:0]);
      chk("R9 high word", ts_hi, t[63:32]);
   endtask

   task automatic expect_skip(input string req);
      chk({req, " stat_vld"}, stat_vld, 1);
      chk({req, " stat_ts"}, stat_ts, 0);
      chk({req, " ts_valid"}, ts_valid, 0);
   endtask

   task automatic t_reset();
      chk("R1 ts_valid", ts_valid, 0);
      chk("R1 stat_vld", stat_vld, 0);
      chk("R1 stat_ts", stat_ts, 0);
      chk("R1 ts words", {ts_hi, ts_lo}, 64'h0);
   endtask

   task automatic t_v2();
      cfg_enable = 1'b1; cfg_mode = 2'b10;
      send(16'h88F7, 0, 16'd0, 4'd2, 8'h00, 64'h0123_4567_89AB_CDEF, 0);
      expect_stamp("R2 L2 event", 64'h0123_4567_89AB_CDEF);
      read_hi();
      send(16'h0800, 1, 16'd319, 4'd2, 8'h03, 64'hFEDC_BA98_7654_3210, 0);
      expect_stamp("R3 UDP path-delay", 64'hFEDC_BA98_7654_3210);
      read_hi();
      send(16'h0800, 1, 16'd319, 4'd2, 8'h08, 64'h11, 0);
      expect_skip("R3 general type");
      send(16'h0800, 1, 16'd320, 4'd2, 8'h00, 64'h12, 0);
      expect_skip("R3 other port");
      send(16'h88F7, 0, 16'd0, 4'd1, 8'h00, 64'h13, 0);
      expect_skip("R10 version mismatch");
   endtask

   task automatic t_v1();
      cfg_mode = 2'b01; cfg_v1_msg = 8'h01;
      send(16'h0800, 1, 16'd319, 4'd1, 8'h00, 64'h21, 0);
      expect_skip("R4 other control byte");
      send(16'h88F7, 0, 16'd0, 4'd1, 8'h01, 64'h22, 0);
      expect_skip("R4 L2 frame");
      send(16'h0800, 1, 16'd319, 4'd1, 8'h01, 64'h0000_00AA_5555_0001, 0);
      expect_stamp("R4 selected byte", 64'h0000_00AA_5555_0001);
      read_hi();
   endtask

   task automatic t_lockout();
      cfg_mode = 2'b10;
      send(16'h88F7, 0, 16'd0, 4'd2, 8'h01, 64'hA5A5_0000_0000_0001, 0);
      expect_stamp("R5 first", 64'hA5A5_0000_0000_0001);
      send(16'h88F7, 0, 16'd0, 4'd2, 8'h00, 64'h5A5A_0000_0000_0002, 0);
      chk("R5 stat_ts locked", stat_ts, 0);
      chk("R7 stat_vld locked", stat_vld, 1);
      chk("R5 value held", {ts_hi, ts_lo}, 64'hA5A5_0000_0000_0001);
      send(16'h88F7, 0, 16'd0, 4'd2, 8'h00, 64'h33, 1);
      chk("R6 same-cycle read stat_ts", stat_ts, 0);
      chk("R6 same-cycle read ts_valid", ts_valid, 0);
      send(16'h88F7, 0, 16'd0, 4'd2, 8'h02, 64'h0BAD_CAFE_0000_0004, 0);
      expect_stamp("R6 after clear", 64'h0BAD_CAFE_0000_0004);
      @(negedge clk);
      chk("R7 status one cycle", stat_vld, 0);
      chk("R7 stamp one cycle", stat_ts, 0);
      read_hi();
   endtask

   task automatic t_disable();
      cfg_enable = 1'b0; cfg_mode = 2'b10;
      send(16'h88F7, 0, 16'd0, 4'd2, 8'h00, 64'h41, 0);
      expect_skip("R8 disabled");
      cfg_enable = 1'b1; cfg_mode = 2'b00;
      send(16'h88F7, 0, 16'd0, 4'd2, 8'h00, 64'h42, 0);
      expect_skip("R8 mode off");
      cfg_mode = 2'b11;
      send(16'h0800, 1, 16'd319, 4'd2, 8'h00, 64'h43, 0);
      expect_skip("R8 mode reserved");
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_v2();
      t_v1();
      t_lockout();
      t_disable();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule